// File: doc/BRIEF.md
# Fine Binary-Search Period Tracker

This block takes over period control once a coarse loop has brought the phase error under the smallest error the time-to-digital converter can resolve. After that point its only phase input is a single lead/lag bit, sampled on a strobe. It drives a fine-stage period word. When the divided clock leads, the word moves to a longer period. When it lags, the word moves to a shorter period.

A search round steps the period in one direction and adds up the distance covered. It continues until the lead/lag sign reverses, which means the reference lies inside the covered distance. On a reversal the period jumps back to the midpoint of that distance, and both the distance and the step are halved. A single hold sample is allowed per round to escape a region where a step first appears to drift the wrong way. When the distance narrows to the oscillator's minimum control step, the block enters a maintain state. In that state it nudges the word by one LSB per sample.

Top module: `fine_tracker`

## Requirements
- R1: After reset, `period` equals the INIT parameter (128 by default) and `maintain` is 0.
- R2: A cycle in which `sample` is 0 leaves `period` and `maintain` unchanged, whatever the value of `lead`.
- R3: The first sample after reset moves `period` by STEP0 (16 by default): upward when `lead`=1 (divided clock leads), downward when `lead`=0. This sets the accumulated distance to STEP0.
- R4: The first sample in a round whose `lead` equals that of the previous sample holds `period` unchanged. This is the hold slot.
- R5: Each later same-sign sample in the round moves `period` by the current step in the `lead` direction, and adds the step to the accumulated distance.
- R6: A sample whose `lead` differs from the previous one moves `period` by half the accumulated distance (rounded down) in the new `lead` direction. It halves the distance, and sets the step to half its old value but never below `min_step`. It also re-arms the hold slot.
- R7: When a reversal leaves the distance at or below `min_step`, `maintain` rises and stays 1 until reset.
- R8: While `maintain` is 1, each sample moves `period` by exactly one LSB: up for `lead`=1 and down for `lead`=0.
- R9: `period` saturates at 0 and at 2^W-1 and never wraps. The accumulated distance also saturates at 2^W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample | input | 1 | One-cycle strobe: take `lead` this cycle |
| lead | input | 1 | 1 = divided clock leads, 0 = lags |
| min_step | input | W | Oscillator minimum control step, in period LSBs |
| period | output | W | Fine-stage period word |
| maintain | output | 1 | Search finished, one-LSB maintain mode |

## Verification
Every result is registered once, so `period` and `maintain` reflect a strobe on the clock edge that samples it. The bench therefore drives each strobe on a falling edge, lets one rising edge pass, and compares on the next falling edge. Between strobes, idle cycles with `lead` toggling are checked for no movement. Hand-derived sequences fix the values for the step, hold, accumulation and midpoint cases. A sweep over target periods and minimum steps compares every strobe against an arithmetic model of the requirements.

// File: rtl/fine_tracker.sv
module fine_tracker #(
  parameter int W     = 8,
  parameter int INIT  = 128,
  parameter int STEP0 = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic         lead,
  input  logic [W-1:0] min_step,
  output logic [W-1:0] period,
  output logic         maintain
);

  localparam logic [W:0]   TOP  = {1'b0, {W{1'b1}}};
  localparam logic [W-1:0] P0   = W'(INIT);
  localparam logic [W-1:0] S0   = W'(STEP0);
  localparam logic [W-1:0] ONE  = W'(1);

  function automatic logic [W-1:0] move(input logic [W-1:0] base,
                                        input logic [W-1:0] amt,
                                        input logic up);
    logic [W:0] s;
    s = {1'b0, base} + {1'b0, amt};
    if (up)              move = (s > TOP) ? TOP[W-1:0] : s[W-1:0];
    else if (amt > base) move = '0;
    else                 move = base - amt;
  endfunction

  logic [W-1:0] step, range, half_r, half_s, step_h;
  logic [W:0]   acc;
  logic         last_lead, seen, wait_fin;

  logic [W-1:0] period_n, step_n, range_n;
  logic         last_n, seen_n, wait_n, maint_n;

  assign half_r = range >> 1;
  assign half_s = step >> 1;
  assign step_h = (half_s < min_step) ? min_step : half_s;
  assign acc    = {1'b0, range} + {1'b0, step};

  always_comb begin
    period_n = period;
    step_n   = step;
    range_n  = range;
    last_n   = last_lead;
    seen_n   = seen;
    wait_n   = wait_fin;
    maint_n  = maintain;
    if (sample) begin
      if (maintain) begin
        period_n = move(period, ONE, lead);
      end else if (!seen) begin
        period_n = move(period, step, lead);
        range_n  = step;
        seen_n   = 1'b1;
        last_n   = lead;
      end else if (lead == last_lead) begin
        if (!wait_fin) begin
          wait_n = 1'b1;
        end else begin
          period_n = move(period, step, lead);
          range_n  = (acc > TOP) ? TOP[W-1:0] : acc[W-1:0];
        end
      end else begin
        period_n = move(period, half_r, lead);
        range_n  = half_r;
        step_n   = step_h;
        wait_n   = 1'b0;
        last_n   = lead;
        maint_n  = (half_r <= min_step);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period    <= P0;
      step      <= S0;
      range     <= '0;
      last_lead <= 1'b0;
      seen      <= 1'b0;
      wait_fin  <= 1'b0;
      maintain  <= 1'b0;
    end else begin
      period    <= period_n;
      step      <= step_n;
      range     <= range_n;
      last_lead <= last_n;
      seen      <= seen_n;
      wait_fin  <= wait_n;
      maintain  <= maint_n;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(period) && $stable(maintain)); // R2

  AST_MAINT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    maintain |=> maintain); // R7

  AST_MAINT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    maintain && sample |=> (period == $past(period) + ONE) ||
                           (period == $past(period) - ONE) ||
                           $stable(period)); // R8

  AST_FIRST_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    sample && !seen && lead |=> period >= $past(period)); // R3

  AST_WAIT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    sample && !maintain && seen && (lead == last_lead) && !wait_fin
      |=> $stable(period) && wait_fin); // R4

  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    sample && !maintain && seen && (lead != last_lead) |=> !wait_fin); // R6

endmodule

// File: tb/sim_fine_tracker.sv
module sim_fine_tracker;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample = 1'b0;
  logic lead = 1'b0;
  logic [W-1:0] min_step = 8'd1;
  logic [W-1:0] period;
  logic maintain;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  int mp, ms, mr, ml, mseen, mw, mm, mmin;

  fine_tracker #(.W(W), .INIT(128), .STEP0(16)) u0 (
    .clk(clk), .rst_n(rst_n), .sample(sample), .lead(lead),
    .min_step(min_step), .period(period), .maintain(maintain));

  always #5 clk = ~clk;

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mv(input int b, input int a, input int up);
    int s;
    if (up != 0) begin s = b + a; return (s > 255) ? 255 : s; end
    return (a > b) ? 0 : b - a;
  endfunction

  task automatic do_reset(input int mn);
    @(negedge clk);
    rst_n = 1'b0; sample = 1'b0; min_step = W'(mn);
    @(negedge clk);
    rst_n = 1'b1;
    mp = 128; ms = 16; mr = 0; ml = 0; mseen = 0; mw = 0; mm = 0; mmin = mn;
  endtask

  task automatic model(input int ld);
    if (mm != 0) mp = mv(mp, 1, ld);
    else if (mseen == 0) begin
      mp = mv(mp, ms, ld); mr = ms; mseen = 1; ml = ld;
    end else if (ld == ml) begin
      if (mw == 0) mw = 1;
      else begin mp = mv(mp, ms, ld); mr = (mr + ms > 255) ? 255 : mr + ms; end
    end else begin
      mp = mv(mp, mr / 2, ld); mr = mr / 2;
      ms = (ms / 2 < mmin) ? mmin : ms / 2;
      mw = 0; ml = ld;
      if (mr <= mmin) mm = 1;
    end
  endtask

  task automatic pulse(input int ld);
    sample = 1'b1; lead = (ld != 0);
    @(negedge clk);
    sample = 1'b0;
    model(ld);
  endtask

  initial begin
    do_reset(1);
    chk("R1 period", period, 128);
    chk("R1 maintain", maintain, 0);

    pulse(1); chk("R3 first step up", period, 144);
    pulse(1); chk("R4 hold slot", period, 144);
    pulse(1); chk("R5 accumulate step", period, 160);
    for (int i = 0; i < 3; i++) begin
      lead = ~lead; @(negedge clk);
    end
    chk("R2 idle no move", period, 160);
    chk("R2 idle maintain", maintain, 0);
    pulse(0); chk("R6 midpoint after flip", period, 144);
    pulse(0); chk("R4 rearmed hold", period, 144);
    pulse(0); chk("R6 halved step", period, 136);
    pulse(1); chk("R6 second midpoint", period, 148);

    do_reset(1);
    pulse(0); chk("R3 first step down", period, 112);

    do_reset(1);
    for (int i = 0; i < 14; i++) pulse(1);
    chk("R9 saturate high", period, 255);
    do_reset(1);
    for (int i = 0; i < 14; i++) pulse(0);
    chk("R9 saturate low", period, 0);

    for (int mn = 1; mn <= 4; mn = mn * 2) begin
      for (int tgt = 60; tgt <= 200; tgt += 7) begin
        do_reset(mn);
        for (int k = 0; k < 40; k++) begin
          pulse((mp < tgt) ? 1 : 0);
          chk(mm != 0 ? "R8 sweep period" : "R5 R6 sweep period", period, mp);
          chk("R7 sweep maintain", maintain, mm);
        end
        chk("R7 reached maintain", maintain, 1);
        pulse(1); pulse(1);
        chk("R8 maintain up", period, mp);
        pulse(0);
        chk("R8 maintain down", period, mp);
        chk("R7 sticky", maintain, 1);
      end
    end
    finish_run();
  end
endmodule